// File: doc/BRIEF.md
# Five-Port I2C Hub Repeater Logic

This block is the clocked control logic of a bidirectional I2C hub with five ports. Every port has a sensed line level and a pull-low request for each of its two wires, data and clock. A low that a device outside the hub puts on one connected port is repeated onto every other connected port, so all segments behave as one bus. Port 0 is always connected. Ports 1 to 4 can each be cut off from the bus by an enable.

Several hubs can share a pair of wired-AND expansion lines for each wire, called stage 1 and stage 2. Stage 2 is low while some port anywhere is held low by an outside device. Stage 1 is low while the repeated low must be kept. The hub records which ports are driven from outside (the source ports) and never treats a low it drives itself as a new source. Because of this, a repeated low cannot feed back on itself and lock the bus. Lines are released in a fixed order: first stage 2, then stage 1, and only then the ports the hub was driving.

The data and clock wires each get their own copy of this logic. Enable requests take effect only after both wires have been quiet for a set number of cycles.

Top module: `i2c_fanout_hub`

## Requirements
- R1: Port 0 (bit 0 of each port vector) has no enable and always takes part. Bit k-1 of `en_req` enables port k, for k from 1 to 4.
- R2: While a port is disabled, an outside low on it changes no output, and the hub never pulls that port low.
- R3: On the first clock edge that sees an outside low on an enabled port, the hub pulls both stage lines of that wire low. One edge later it pulls every other enabled port of that wire low. It never pulls the source port.
- R4: Stage 2 stays pulled low while any local source port is still held. When a source releases while another source still holds, that port is pulled by the hub from the same edge on. Stage 2 is released on the edge that sees the last source go high.
- R5: Stage 1 is released only on an edge where stage 2 is sensed high and one of two things is true: the last-released source port is sensed high, or TIMEOUT cycles (CLK_MHZ × REL_TIMEOUT_NS / 1000, rounded up) of that wait have passed.
- R6: The hub stops pulling its driven ports only on the edge after both stage lines are sensed high.
- R7: A stage line sensed low with no local source (a low from another hub) makes the hub pull every enabled port low on the next edge. In that case the hub does not pull either stage line itself.
- R8: A change on `en_req` takes effect only after IDLE_CYC consecutive edges in which both wires are quiet. A quiet wire has both stage lines high, no source port and no pulled port.
- R9: Activity on one wire never makes the hub pull any line of the other wire.
- R10: After reset, no line is pulled and all four enables are set, whatever the value of `en_req`.
- R11: A port that the hub is pulling is never taken as a source port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 4 | Requested enables for ports 1..4 |
| sda_in | input | 5 | Sensed data line of each port |
| sda_pull | output | 5 | Pull-low request for the data line of each port |
| scl_in | input | 5 | Sensed clock line of each port |
| scl_pull | output | 5 | Pull-low request for the clock line of each port |
| sda_xs1_in | input | 1 | Sensed data expansion stage-1 line |
| sda_xs1_pull | output | 1 | Pull-low for data stage-1 line |
| sda_xs2_in | input | 1 | Sensed data expansion stage-2 line |
| sda_xs2_pull | output | 1 | Pull-low for data stage-2 line |
| scl_xs1_in | input | 1 | Sensed clock expansion stage-1 line |
| scl_xs1_pull | output | 1 | Pull-low for clock stage-1 line |
| scl_xs2_in | input | 1 | Sensed clock expansion stage-2 line |
| scl_xs2_pull | output | 1 | Pull-low for clock stage-2 line |

## Verification
The assertions check on every cycle that a pulled port is never a source, and that stage 2 low always comes with stage 1 low. They also check that stage 1 and the pulled ports are released only after the sensed stage lines allow it, that disabled ports are never pulled, that the release timer stays within its limit, and that enables change only after a quiet cycle. Only the bench scenarios can show the exact edge on which each line falls and rises, and that every pattern of source port and enable set is fanned out correctly on each wire. The same holds for the two-holder hand-over, the timeout path when the last holder sits on another hub, and the fact that enable changes are held back while the bus is busy.

// File: rtl/hub_pkg.sv
package hub_pkg;

    localparam int LANES    = 2;
    localparam int LANE_SDA = 0;
    localparam int LANE_SCL = 1;

    // one expansion signal pair: stage 1 (hold) and stage 2 (external owner)
    typedef struct packed {
        logic s1;
        logic s2;
    } xbus_t;

    // cycles covering a time span, rounded up, never below one
    function automatic int ns_to_cycles(int mhz, int ns);
        int c;
        c = (mhz * ns + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/hub_rel_timer.sv
module hub_rel_timer #(
    parameter int LIMIT = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_q;

    assign done = run && (cnt_q == W'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || done) cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    assert_tmr_range_R5: assert property (@(posedge clk) disable iff (rst)
        cnt_q < W'(LIMIT));

endmodule

// File: rtl/hub_en_gate.sv
module hub_en_gate #(
    parameter int NEN      = 4,
    parameter int IDLE_CYC = 200
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           quiet,
    input  logic [NEN-1:0] en_req,
    output logic [NEN-1:0] en_act
);
    localparam int CW = $clog2(IDLE_CYC + 1);

    logic [CW-1:0]  cnt_q;
    logic [NEN-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            en_q  <= '1;
        end else if (!quiet) begin
            cnt_q <= '0;
        end else if (cnt_q >= CW'(IDLE_CYC - 1)) begin
            en_q  <= en_req;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign en_act = en_q;

    // enables move only at the end of a quiet stretch
    assert_en_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(en_q) |-> $past(quiet));

endmodule

// File: rtl/hub_lane.sv
module hub_lane
    import hub_pkg::*;
#(
    parameter int NPORT  = 5,
    parameter int TO_CYC = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-1:0] en,
    input  logic [NPORT-1:0] line_in,
    output logic [NPORT-1:0] pull,
    input  xbus_t            xin,
    output xbus_t            xpull,
    output logic             quiet
);
    logic [NPORT-1:0] owner_q, owner_n;   // ports held low from outside
    logic [NPORT-1:0] relm_q, relm_n;     // last source, left undriven
    logic [NPORT-1:0] pull_q, pull_n;
    logic [NPORT-1:0] ext_low;
    logic             s1_q, s1_n, s2_q;
    logic             active, waiting, risen, tmo;

    always_comb begin
        ext_low = en & ~line_in & ~pull_q & ~owner_q;
        owner_n = en & ((owner_q & ~line_in) | ext_low);
        risen   = |(relm_q & line_in);
        waiting = s1_q && !(|owner_q) && xin.s2;
        s1_n    = (|owner_n) || (s1_q && !(waiting && (risen || tmo)));
        if (xin.s1 && xin.s2)
            relm_n = '0;
        else
            relm_n = en & ((relm_q & {NPORT{s2_q | xin.s2}})
                         | (owner_q & ~owner_n & {NPORT{~|owner_n}}));
        active  = !xin.s1 || !xin.s2;
        pull_n  = en & ~owner_n & ~relm_n & {NPORT{active}};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= '0;
            relm_q  <= '0;
            pull_q  <= '0;
            s1_q    <= 1'b0;
            s2_q    <= 1'b0;
        end else begin
            owner_q <= owner_n;
            relm_q  <= relm_n;
            pull_q  <= pull_n;
            s1_q    <= s1_n;
            s2_q    <= |owner_n;
        end
    end

    hub_rel_timer #(.LIMIT(TO_CYC)) u_tmr (
        .clk (clk),
        .rst (rst),
        .run (waiting && !risen),
        .done(tmo)
    );

    assign pull     = pull_q;
    assign xpull.s1 = s1_q;
    assign xpull.s2 = s2_q;
    assign quiet    = xin.s1 && xin.s2 && !(|owner_q) && !(|pull_q);

    assert_no_self_source_R11: assert property (@(posedge clk) disable iff (rst)
        (owner_q & pull_q) == '0);

    assert_s2_needs_s1_R3: assert property (@(posedge clk) disable iff (rst)
        s2_q |-> s1_q);

    assert_s1_after_s2_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(s1_q) |-> $past(xin.s2));

    assert_release_order_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(|pull_q) |-> $past(xin.s1 && xin.s2));

    for (genvar i = 0; i < NPORT; i++) begin : g_iso
        assert_isolated_R2: assert property (@(posedge clk) disable iff (rst)
            !en[i] |-> !pull_q[i]);
    end

endmodule

// File: rtl/i2c_fanout_hub.sv
module i2c_fanout_hub
    import hub_pkg::*;
#(
    parameter int NPORT          = 5,
    parameter int CLK_MHZ        = 100,
    parameter int REL_TIMEOUT_NS = 1000,
    parameter int IDLE_CYC       = 200
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPORT-2:0] en_req,
    input  logic [NPORT-1:0] sda_in,
    output logic [NPORT-1:0] sda_pull,
    input  logic [NPORT-1:0] scl_in,
    output logic [NPORT-1:0] scl_pull,
    input  logic             sda_xs1_in,
    output logic             sda_xs1_pull,
    input  logic             sda_xs2_in,
    output logic             sda_xs2_pull,
    input  logic             scl_xs1_in,
    output logic             scl_xs1_pull,
    input  logic             scl_xs2_in,
    output logic             scl_xs2_pull
);
    localparam int NEN    = NPORT - 1;
    localparam int TO_CYC = ns_to_cycles(CLK_MHZ, REL_TIMEOUT_NS);

    logic [NPORT-1:0] l_in   [LANES];
    logic [NPORT-1:0] l_pull [LANES];
    xbus_t            l_xin  [LANES];
    xbus_t            l_xpull[LANES];
    logic [LANES-1:0] l_quiet;
    logic [NEN-1:0]   en_act;
    logic [NPORT-1:0] en_full;

    assign en_full = {en_act, 1'b1};   // port 0 is always connected

    assign l_in[LANE_SDA]     = sda_in;
    assign l_in[LANE_SCL]     = scl_in;
    assign l_xin[LANE_SDA].s1 = sda_xs1_in;
    assign l_xin[LANE_SDA].s2 = sda_xs2_in;
    assign l_xin[LANE_SCL].s1 = scl_xs1_in;
    assign l_xin[LANE_SCL].s2 = scl_xs2_in;

    assign sda_pull     = l_pull[LANE_SDA];
    assign scl_pull     = l_pull[LANE_SCL];
    assign sda_xs1_pull = l_xpull[LANE_SDA].s1;
    assign sda_xs2_pull = l_xpull[LANE_SDA].s2;
    assign scl_xs1_pull = l_xpull[LANE_SCL].s1;
    assign scl_xs2_pull = l_xpull[LANE_SCL].s2;

    hub_en_gate #(.NEN(NEN), .IDLE_CYC(IDLE_CYC)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .quiet (&l_quiet),
        .en_req(en_req),
        .en_act(en_act)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        hub_lane #(.NPORT(NPORT), .TO_CYC(TO_CYC)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .en     (en_full),
            .line_in(l_in[l]),
            .pull   (l_pull[l]),
            .xin    (l_xin[l]),
            .xpull  (l_xpull[l]),
            .quiet  (l_quiet[l])
        );
    end

endmodule

// File: tb/i2c_fanout_hub_bench.sv
module i2c_fanout_hub_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IDLE       = 4;
    localparam int TO         = 8;   // 8 MHz x 1000 ns

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] en_req = 4'h0;
    logic [4:0] ext  [2];
    logic       rem1 [2];
    logic       rem2 [2];

    logic [4:0] sda_in, sda_pull, scl_in, scl_pull;
    logic sda_xs1_in, sda_xs1_pull, sda_xs2_in, sda_xs2_pull;
    logic scl_xs1_in, scl_xs1_pull, scl_xs2_in, scl_xs2_pull;

    int nchk  = 0;
    int nfail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // wired-AND bus model
    assign sda_in     = ~(sda_pull | ext[0]);
    assign scl_in     = ~(scl_pull | ext[1]);
    assign sda_xs1_in = ~(sda_xs1_pull | rem1[0]);
    assign sda_xs2_in = ~(sda_xs2_pull | rem2[0]);
    assign scl_xs1_in = ~(scl_xs1_pull | rem1[1]);
    assign scl_xs2_in = ~(scl_xs2_pull | rem2[1]);

    i2c_fanout_hub #(.NPORT(5), .CLK_MHZ(8), .REL_TIMEOUT_NS(1000), .IDLE_CYC(IDLE))
    u_i2c_fanout_hub (
        .clk(clk), .rst(rst), .en_req(en_req),
        .sda_in(sda_in), .sda_pull(sda_pull),
        .scl_in(scl_in), .scl_pull(scl_pull),
        .sda_xs1_in(sda_xs1_in), .sda_xs1_pull(sda_xs1_pull),
        .sda_xs2_in(sda_xs2_in), .sda_xs2_pull(sda_xs2_pull),
        .scl_xs1_in(scl_xs1_in), .scl_xs1_pull(scl_xs1_pull),
        .scl_xs2_in(scl_xs2_in), .scl_xs2_pull(scl_xs2_pull)
    );

    function automatic logic [4:0] lpull(int l);
        return (l == 0) ? sda_pull : scl_pull;
    endfunction
    function automatic logic ls1(int l);
        return (l == 0) ? sda_xs1_pull : scl_xs1_pull;
    endfunction
    function automatic logic ls2(int l);
        return (l == 0) ? sda_xs2_pull : scl_xs2_pull;
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", nchk, nfail);
    endtask

    task automatic set_en(logic [3:0] e);
        en_req = e;
        step(IDLE + 3);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        for (int l = 0; l < 2; l++) begin
            ext[l] = '0; rem1[l] = 1'b0; rem2[l] = 1'b0;
        end
        step(3);
        chk("R10 pulls in reset", {sda_pull[4:2], sda_xs1_pull, scl_xs2_pull}, 5'b0);
        chk("R10 scl pulls in reset", scl_pull, 5'b0);
        // leave reset with en_req = 0; reset enables must still be all on
        rst = 1'b0;
        ext[0][0] = 1'b1;
        step(1);
        chk("R3 stage lines first", {3'b0, sda_xs1_pull, sda_xs2_pull}, 5'b00011);
        chk("R3 ports one edge later", sda_pull, 5'b0);
        step(1);
        chk("R10 reset enables all on", sda_pull, 5'b11110);
        chk("R9 other lane idle", {scl_pull}, 5'b0);
        ext[0][0] = 1'b0;
        step(3);
        chk("R6 all released", sda_pull, 5'b0);
        step(IDLE + 3);
        // en_req = 0 now applied: port 0 still active, nothing to fan out
        ext[0][0] = 1'b1;
        step(2);
        chk("R1 port0 always on", {sda_pull[4:1], sda_xs1_pull}, 5'b00001);
        ext[0][0] = 1'b0;
        step(4);

        // R8: enable change held back while busy
        set_en(4'hF);
        ext[1][0] = 1'b1;
        step(2);
        en_req = 4'h0;
        step(IDLE + 3);
        chk("R8 no change while busy", scl_pull, 5'b11110);
        ext[1][0] = 1'b0;
        step(3);
        chk("R6 released", scl_pull, 5'b0);
        step(IDLE + 2);
        ext[1][0] = 1'b1;
        step(2);
        chk("R8 applied after idle", {scl_pull[4:1], scl_xs1_pull}, 5'b00001);
        ext[1][0] = 1'b0;
        step(4);

        // exhaustive sweep: lane x enable pattern x source port
        for (int l = 0; l < 2; l++) begin
            for (int e = 0; e < 16; e++) begin
                set_en(4'(e));
                for (int p = 0; p < 5; p++) begin
                    logic [4:0] full, expp;
                    logic       a;
                    full = {4'(e), 1'b1};
                    a    = full[p];
                    expp = a ? (full & ~(5'b00001 << p)) : 5'b0;
                    ext[l][p] = 1'b1;
                    step(1);
                    chk(a ? "R3 stage1 on source" : "R2 disabled source",
                        {3'b0, ls1(l), ls2(l)}, {3'b0, a, a});
                    chk("R3 no port pull yet", lpull(l), 5'b0);
                    step(1);
                    chk(a ? "R3 fan-out" : "R2 no fan-out", lpull(l), expp);
                    chk("R9 other lane", {lpull(1 - l)}, 5'b0);
                    chk("R9 other stage lines", {3'b0, ls1(1 - l), ls2(1 - l)}, 5'b0);
                    ext[l][p] = 1'b0;
                    step(1);
                    chk("R4 stage2 released", {3'b0, ls1(l), ls2(l)}, {3'b0, a, 1'b0});
                    chk("R6 pulls held", lpull(l), expp);
                    step(1);
                    chk("R5 stage1 on rise", {4'b0, ls1(l)}, 5'b0);
                    chk("R6 pulls held to last", lpull(l), expp);
                    step(1);
                    chk("R6 pulls released", lpull(l), 5'b0);
                    step(1);
                end
            end
        end

        set_en(4'hF);
        // R4: two outside holders, hand-over
        ext[0][0] = 1'b1; ext[0][2] = 1'b1;
        step(2);
        chk("R4 two sources", sda_pull, 5'b11010);
        ext[0][0] = 1'b0;
        step(1);
        chk("R4 early releaser pulled", sda_pull, 5'b11011);
        chk("R4 stage2 still low", {4'b0, sda_xs2_pull}, 5'b1);
        ext[0][2] = 1'b0;
        step(1);
        chk("R4 stage2 up after last", {3'b0, sda_xs1_pull, sda_xs2_pull}, 5'b00010);
        chk("R4 last source undriven", sda_pull, 5'b11011);
        step(1);
        chk("R5 stage1 released", {4'b0, sda_xs1_pull}, 5'b0);
        step(1);
        chk("R6 pulls released", sda_pull, 5'b0);
        step(2);

        // R7: low from another hub
        rem1[1] = 1'b1;
        step(1);
        chk("R7 follower fan-out", scl_pull, 5'b11111);
        chk("R7 no own stage pull", {3'b0, scl_xs1_pull, scl_xs2_pull}, 5'b0);
        rem1[1] = 1'b0;
        step(1);
        chk("R7 follower release", scl_pull, 5'b0);
        step(2);

        // R5: last holder on another hub, timeout path
        ext[0][1] = 1'b1; rem2[0] = 1'b1;
        step(2);
        chk("R5 setup fan-out", sda_pull, 5'b11101);
        ext[0][1] = 1'b0;
        step(2);
        chk("R5 released port repulled", sda_pull, 5'b11111);
        chk("R5 stage1 held", {3'b0, sda_xs1_pull, sda_xs2_pull}, 5'b00010);
        rem2[0] = 1'b0;
        step(TO - 1);
        chk("R5 stage1 before timeout", {4'b0, sda_xs1_pull}, 5'b1);
        step(1);
        chk("R5 stage1 at timeout", {4'b0, sda_xs1_pull}, 5'b0);
        step(1);
        chk("R6 pulls after timeout", sda_pull, 5'b0);
        step(2);

        summary();
        $finish;
    end

endmodule